// File: doc/BRIEF.md
# Walsh-Hadamard Spectral Bit-Stream Perturber

This block takes the bit-stream that one test input receives over N clock periods (default 128) and produces a new stream of the same length. The new stream keeps the dominant spectral content of the original. Each bit is mapped to a ±1 value. A fast Walsh-Hadamard transform then produces N spectral coefficients. Each coefficient is classed by its power relative to the total.

Coefficients whose normalized power reaches 1/N are kept. Every weaker coefficient is overwritten with a small signed pseudo-random value drawn from a 16-bit LFSR. The same butterfly network is then run again as the inverse transform, and the sign of each result gives the new bit.

A test generator loads a stored stream serially and pulses `start` with a seed. After a fixed processing time it receives a `done` pulse and the new stream, one bit per cycle. Running the block again with different seeds yields a family of streams with the same spectral profile.

Top module: `wh_perturb`

## Requirements
- R1: Bits enter on `in_bit` in each cycle where `in_valid` is high, while the block is idle. The k-th accepted bit fills stream position k, and the position count starts at 0 after reset and after each output burst. A 1 is stored as +1 and a 0 as -1.
- R2: The forward step computes c_i = Σ_k H(i,k)·x_k, where H(i,k) = (-1)^popcount(i AND k) is the naturally ordered Hadamard matrix. Every forward coefficient therefore lies within ±N.
- R3: A coefficient with c² ≥ N is essential and passes to the inverse step unchanged. This is the test "normalized power c²/N² at or above 1/N".
- R4: Coefficients with c² < N are replaced, in index order 0..N-1. The magnitude of the new value is LFSR bits [MB-1:0], where MB = floor(log2(N)/2) (3 for N = 128), so that its square stays below N. The value is negative when LFSR bit 15 is 1. The LFSR then steps once, and it does not step for essential coefficients.
- R5: The LFSR is a 16-bit Fibonacci register that shifts toward the MSB with new bit 0 = b15^b13^b12^b10. It loads from `seed` when a start is accepted, and an all-zero seed loads as 16'h0001.
- R6: The inverse step computes y = H·c' with no scaling. Output bit k is 1 when y_k ≥ 0 (a zero result gives 1) and 0 when y_k < 0.
- R7: `done` is high for exactly one cycle, N·log2(N) + N cycles after the edge that accepts `start` (1024 for N = 128). `out_valid` is high in that same cycle and in the next N-1 cycles, and it then falls. Stream positions 0..N-1 are presented on `out_bit` in that order.
- R8: `start` and `in_valid` have no effect from the accepted start until the output burst ends. The result equals that of an undisturbed run, and the next load still begins at position 0.
- R9: After reset, `done` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_bit` during loading |
| in_bit | input | 1 | Next bit of the stream to perturb |
| start | input | 1 | Begins processing of the loaded stream |
| seed | input | 16 | LFSR seed, sampled with `start` |
| done | output | 1 | One-cycle pulse when the new stream is ready |
| out_valid | output | 1 | Qualifies `out_bit` |
| out_bit | output | 1 | New stream, position 0 first |

## Verification
Only one result has a latency: `done` is due N·log2(N)+N rising edges after the edge that samples `start`. The bench counts those edges one by one and checks `done` at the falling edge after each of them, so an early, late or missing pulse is reported with its count. The N output bits are then due on consecutive cycles starting at the `done` cycle, and `out_valid` must be low in the cycle after the last bit. Both are sampled on falling edges. The expected bits come from a transform-threshold-replace-inverse model built from R1 to R6, run on the same pattern and seed.

// File: rtl/wh_perturb.sv
module wh_perturb #(
  parameter int N  = 128,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic          start,
  input  logic [SW-1:0] seed,
  output logic          done,
  output logic          out_valid,
  output logic          out_bit
);
  localparam int LOGN = $clog2(N);
  localparam int AW   = 2 * LOGN + 2;
  localparam int PW   = $clog2(LOGN + 1);
  localparam int MB   = LOGN / 2;
  localparam logic [LOGN-1:0] LAST_BF  = LOGN'(N / 2 - 1);
  localparam logic [LOGN-1:0] LAST_IX  = LOGN'(N - 1);
  localparam logic [PW-1:0]   LAST_PS  = PW'(LOGN - 1);

  typedef enum logic [2:0] {S_IDLE, S_FWD, S_THR, S_INV, S_OUT} st_t;

  st_t                    st;
  logic [LOGN-1:0]        idx;
  logic [PW-1:0]          pass;
  logic [SW-1:0]          lfsr;
  logic signed [AW-1:0]   mem [N];

  logic [LOGN-1:0]        ja, lo_mask, ia, ib;
  logic signed [AW-1:0]   xa, xb, cur, noise;
  logic signed [2*AW-1:0] sq;
  logic                   essential;
  logic [SW-1:0]          lfsr_nx;

  always_comb begin
    ja      = {1'b0, idx[LOGN-2:0]};
    lo_mask = (LOGN'(1) << pass) - LOGN'(1);
    ia      = ((ja >> pass) << (pass + PW'(1))) | (ja & lo_mask);
    ib      = ia | (LOGN'(1) << pass);
  end

  assign xa        = mem[ia];
  assign xb        = mem[ib];
  assign cur       = mem[idx];
  assign sq        = cur * cur;
  assign essential = sq >= $signed((2*AW)'(N));
  assign noise     = lfsr[SW-1] ? -$signed(AW'(lfsr[MB-1:0])) : $signed(AW'(lfsr[MB-1:0]));
  assign lfsr_nx   = {lfsr[SW-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  assign out_valid = (st == S_OUT);
  assign out_bit   = ~cur[AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      pass <= '0;
      lfsr <= SW'(1);
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            st   <= S_FWD;
            idx  <= '0;
            pass <= '0;
            lfsr <= (seed == '0) ? SW'(1) : seed;
          end else if (in_valid) begin
            mem[idx] <= in_bit ? AW'(1) : {AW{1'b1}};
            idx      <= idx + LOGN'(1);
          end
        end
        S_FWD, S_INV: begin
          mem[ia] <= xa + xb;
          mem[ib] <= xa - xb;
          if (idx == LAST_BF) begin
            idx <= '0;
            if (pass == LAST_PS) begin
              pass <= '0;
              if (st == S_FWD) st <= S_THR;
              else begin
                st   <= S_OUT;
                done <= 1'b1;
              end
            end else begin
              pass <= pass + PW'(1);
            end
          end else begin
            idx <= idx + LOGN'(1);
          end
        end
        S_THR: begin
          if (!essential) begin
            mem[idx] <= noise;
            lfsr     <= lfsr_nx;
          end
          idx <= idx + LOGN'(1);
          if (idx == LAST_IX) st <= S_INV;
        end
        S_OUT: begin
          idx <= idx + LOGN'(1);
          if (idx == LAST_IX) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (lfsr != '0));

  a_r2_coef_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_THR) |-> (cur <= $signed(AW'(N)) && cur >= -$signed(AW'(N))));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INV && start) |=> (st == S_INV || st == S_OUT));
endmodule

// File: tb/wh_perturb_tb.sv
module wh_perturb_tb;
  localparam int N    = 128;
  localparam int LOGN = 7;
  localparam int MB   = LOGN / 2;
  localparam int LAT  = N * LOGN + N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, start = 1'b0;
  logic [15:0] seed = '0;
  logic done, out_valid, out_bit;
  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  wh_perturb #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .start(start), .seed(seed), .done(done), .out_valid(out_valid), .out_bit(out_bit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung after %0d cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [N-1:0] pat, input logic [15:0] sd);
    int v[N];
    int a, b, mag;
    logic [15:0] l;
    logic [N-1:0] r;
    l = (sd == 16'h0) ? 16'h0001 : sd;
    for (int k = 0; k < N; k++) v[k] = pat[k] ? 1 : -1;
    for (int h = 1; h < N; h = h * 2)
      for (int i = 0; i < N; i = i + 2 * h)
        for (int j = i; j < i + h; j++) begin
          a = v[j]; b = v[j + h]; v[j] = a + b; v[j + h] = a - b;
        end
    for (int k = 0; k < N; k++)
      if (v[k] * v[k] < N) begin
        mag  = int'(l[MB-1:0]);
        v[k] = l[15] ? -mag : mag;
        l    = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
      end
    for (int h = 1; h < N; h = h * 2)
      for (int i = 0; i < N; i = i + 2 * h)
        for (int j = i; j < i + h; j++) begin
          a = v[j]; b = v[j + h]; v[j] = a + b; v[j + h] = a - b;
        end
    for (int k = 0; k < N; k++) r[k] = (v[k] >= 0);
    return r;
  endfunction

  task automatic load_stream(input logic [N-1:0] pat);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); in_valid = 1'b1; in_bit = pat[k];
    end
    @(negedge clk); in_valid = 1'b0; in_bit = 1'b0;
  endtask

  task automatic run_case(input string name, input logic [N-1:0] pat,
                          input logic [15:0] sd, input bit disturb);
    logic [N-1:0] got, exp;
    int n;
    load_stream(pat);
    seed = sd; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    n = 0;
    while (n < LAT + 20) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
      if (disturb && (n == 10 || n == 600 || n == 900)) begin
        start = 1'b1; in_valid = 1'b1; in_bit = ~in_bit; seed = 16'h1234;
      end else begin
        start = 1'b0; in_valid = 1'b0;
      end
    end
    start = 1'b0; in_valid = 1'b0;
    $display("%s: done after %0d cycles", name, n);
    check("R7 done latency", n == LAT && done, n, LAT);
    got = '0;
    for (int k = 0; k < N; k++) begin
      if (k > 0) @(negedge clk);
      if (!out_valid) begin
        check("R7 out_valid during burst", 1'b0, k, 1);
        break;
      end
      got[k] = out_bit;
    end
    exp = model(pat, sd);
    check("R1-model R6 new stream bits", got == exp, got[63:0], exp[63:0]);
    @(negedge clk);
    check("R7 out_valid falls after burst", !out_valid && !done, out_valid, 0);
  endtask

  initial begin
    logic [N-1:0] p;
    logic [31:0] g;
    #12;
    @(negedge clk);
    check("R9 done low in reset", done == 1'b0, done, 0);
    check("R9 out_valid low in reset", out_valid == 1'b0, out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", !done && !out_valid, {done, out_valid}, 0);

    run_case("R2 R3 all ones", {N{1'b1}}, 16'hACE1, 1'b0);
    for (int k = 0; k < N; k++) p[k] = k[0];
    run_case("R3 R4 alternating", p, 16'hBEEF, 1'b0);
    g = 32'h1234_5678;
    for (int k = 0; k < N; k++) begin
      g = g * 32'd1664525 + 32'd1013904223; p[k] = g[29];
    end
    run_case("R4 pseudo-random", p, 16'h0F0F, 1'b0);
    run_case("R5 zero seed", p, 16'h0000, 1'b0);
    for (int k = 0; k < N; k++) p[k] = (k % 16) < 5;
    run_case("R8 disturbed run", p, 16'h5A5A, 1'b1);
    run_case("R1 R8 load restarts at 0", ~p, 16'h7777, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule